// File: doc/BRIEF.md
# Set/Clear Pulse Control Register

This block sits behind one 32-bit host write port and one 32-bit host read port. Each adjacent pair of command bits drives one control output through a JK-style element. The even bit of the pair is the set command and the odd bit is the clear command. The host writes a one to the wanted bit and then writes zero again. Because only a rising command bit acts, the host never keeps a shadow copy of what it wrote. The held control state lives only in the fabric and is returned on the status word, so the host can read it at any time.

The block also drives two interrupt request lines to the host: a fast one and a standard one. The host sees a request as a positive transition on a line. A fabric event raises its line. The line stays high until the host acknowledges it. It then falls and stays low for at least one guard interval before it can rise again, so every request reaches the host as a separate edge. Events that arrive while a line is high, or during its guard interval, are remembered and raise the line again once the guard interval ends.

Top module: `pulse_ctrl_reg`

## Requirements
- R1: While `rst` is sampled high, every control output, every status bit and both request lines are zero on the following cycle. The remembered previous command word is also reset to zero.
- R2: When command bit 2i goes from 0 to 1 between two consecutive clock samples and bit 2i+1 does not, control output i is 1 from the next cycle on.
- R3: When command bit 2i+1 goes from 0 to 1 between two consecutive clock samples and bit 2i does not, control output i is 0 from the next cycle on.
- R4: When bits 2i and 2i+1 both go from 0 to 1 in the same sample, control output i inverts.
- R5: A command bit that stays high, stays low or falls has no effect. In particular, a clear edge acts while the set bit of the same pair is still held high.
- R6: Status bit i equals control output i for i below 16. Status bits 31 down to 16 read as zero.
- R7: When a line is idle and its event input is sampled high, the request line is high from the next cycle. Each cycle in which the event input is high counts as one request.
- R8: A high request line stays high until its acknowledge input is sampled high, and it is low on the cycle after that.
- R9: After it falls, a request line stays low for GAP_CYC cycles (default 1). Requests that arrive while the line is high or inside the gap are held. If one is held, the line rises on the first cycle after the gap.
- R10: An acknowledge that is sampled while its line is low has no effect.
- R11: The fast and standard lines each have their own event and acknowledge inputs, and neither affects the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 32 | Command word from the host write port; bit pairs (2i, 2i+1) are set/clear |
| status_o | output | 32 | Status word for the host read port; low bits mirror the control outputs |
| ctrl_o | output | 16 | Held control outputs |
| fast_evt_i | input | 1 | Request event for the fast line |
| std_evt_i | input | 1 | Request event for the standard line |
| fast_ack_i | input | 1 | Host acknowledge for the fast line |
| std_ack_i | input | 1 | Host acknowledge for the standard line |
| fast_req_o | output | 1 | Fast interrupt request line, edge-signalled |
| std_req_o | output | 1 | Standard interrupt request line, edge-signalled |

## Verification
Two pairs of events can land in the same cycle. The set and clear edges of one pair can rise together, and a new request event can arrive in the very cycle its line is acknowledged. The bench provokes the first with command words whose pairs go from 00 to 11 in one write, mixed with pairs that only set or only clear. It provokes the second by pulsing an event together with the acknowledge, and again inside the guard cycle. A behavioural model predicts every output on every clock: it inverts a pair on a double edge, and it remembers the request and makes the line rise again once the gap has passed.

// File: rtl/pulse_ctrl_pkg.sv
package pulse_ctrl_pkg;

  typedef enum logic [1:0] {
    LN_IDLE = 2'd0,
    LN_HIGH = 2'd1,
    LN_GAP  = 2'd2
  } line_state_e;

  // Next value of a JK element given set (j) and clear (k) edges.
  function automatic logic jk_step(input logic q, input logic j, input logic k);
    logic r;
    case ({j, k})
      2'b10:   r = 1'b1;
      2'b01:   r = 1'b0;
      2'b11:   r = ~q;
      default: r = q;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmd_edge_det.sv
module cmd_edge_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cmd_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cmd_i;
  end

  assign rise_o = rst ? '0 : (cmd_i & ~prev_q);
endmodule

// File: rtl/jk_ctrl_bank.sv
module jk_ctrl_bank
  import pulse_ctrl_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] rise_i,
  output logic [N-1:0]   set_hit_o,
  output logic [N-1:0]   clr_hit_o,
  output logic [N-1:0]   ctrl_o
);
  logic [N-1:0] q_r;
  logic [N-1:0] q_n;

  for (genvar g = 0; g < N; g++) begin : g_pair
    assign set_hit_o[g] = rise_i[2*g];
    assign clr_hit_o[g] = rise_i[2*g+1];
    assign q_n[g]       = jk_step(q_r[g], set_hit_o[g], clr_hit_o[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= q_n;
  end

  assign ctrl_o = q_r;
endmodule

// File: rtl/req_line.sv
module req_line
  import pulse_ctrl_pkg::*;
#(
  parameter int GAP_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic ack_i,
  output logic req_o
);
  localparam int CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);

  line_state_e state_q, state_n;
  logic          pend_q, pend_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          want;
  logic          gap_last;

  assign want     = evt_i | pend_q;
  assign gap_last = (cnt_q == CW'(GAP_CYC - 1));

  always_comb begin
    state_n = state_q;
    pend_n  = pend_q | evt_i;
    cnt_n   = cnt_q;
    case (state_q)
      LN_IDLE: begin
        if (want) begin
          state_n = LN_HIGH;
          pend_n  = 1'b0;
        end
      end
      LN_HIGH: begin
        if (ack_i) begin
          state_n = LN_GAP;
          cnt_n   = '0;
        end
      end
      LN_GAP: begin
        if (gap_last) begin
          if (want) begin
            state_n = LN_HIGH;
            pend_n  = 1'b0;
          end else begin
            state_n = LN_IDLE;
          end
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      default: state_n = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LN_IDLE;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      cnt_q   <= cnt_n;
    end
  end

  assign req_o = (state_q == LN_HIGH);
endmodule

// File: rtl/pulse_ctrl_reg.sv
module pulse_ctrl_reg #(
  parameter int NUM_CTRL = 16,
  parameter int STAT_W   = 32,
  parameter int GAP_CYC  = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NUM_CTRL-1:0] cmd_i,
  output logic [STAT_W-1:0]     status_o,
  output logic [NUM_CTRL-1:0]   ctrl_o,
  input  logic                  fast_evt_i,
  input  logic                  std_evt_i,
  input  logic                  fast_ack_i,
  input  logic                  std_ack_i,
  output logic                  fast_req_o,
  output logic                  std_req_o
);
  localparam int CMD_W = 2 * NUM_CTRL;
  localparam int PAD_W = STAT_W - NUM_CTRL;
  localparam int N_LN  = 2;

  logic [CMD_W-1:0]    cmd_rise;
  logic [NUM_CTRL-1:0] set_hit;
  logic [NUM_CTRL-1:0] clr_hit;
  logic [N_LN-1:0]     ln_evt, ln_ack, ln_req;

  cmd_edge_det #(.W(CMD_W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .cmd_i  (cmd_i),
    .rise_o (cmd_rise)
  );

  jk_ctrl_bank #(.N(NUM_CTRL)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (cmd_rise),
    .set_hit_o (set_hit),
    .clr_hit_o (clr_hit),
    .ctrl_o    (ctrl_o)
  );

  if (PAD_W > 0) begin : g_pad
    assign status_o = {{PAD_W{1'b0}}, ctrl_o};
  end else begin : g_nopad
    assign status_o = ctrl_o[STAT_W-1:0];
  end

  assign ln_evt = {std_evt_i, fast_evt_i};
  assign ln_ack = {std_ack_i, fast_ack_i};

  for (genvar l = 0; l < N_LN; l++) begin : g_line
    req_line #(.GAP_CYC(GAP_CYC)) u_line (
      .clk   (clk),
      .rst   (rst),
      .evt_i (ln_evt[l]),
      .ack_i (ln_ack[l]),
      .req_o (ln_req[l])
    );
  end

  assign fast_req_o = ln_req[0];
  assign std_req_o  = ln_req[1];
endmodule

// File: rtl/pulse_ctrl_reg_chk.sv
module pulse_ctrl_reg_chk #(
  parameter int NUM_CTRL = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_CTRL-1:0] set_hit,
  input logic [NUM_CTRL-1:0] clr_hit,
  input logic [NUM_CTRL-1:0] ctrl_o,
  input logic                fast_req_o,
  input logic                std_req_o,
  input logic                fast_ack_i,
  input logic                std_ack_i
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ctrl_o == '0 && !fast_req_o && !std_req_o));

  // R2
  a_r2_set_edge: assert property (@(posedge clk) disable iff (rst)
    (|(set_hit & ~clr_hit)) |=>
      ((ctrl_o & $past(set_hit & ~clr_hit)) == $past(set_hit & ~clr_hit)));

  // R3
  a_r3_clear_edge: assert property (@(posedge clk) disable iff (rst)
    (|(clr_hit & ~set_hit)) |=> ((ctrl_o & $past(clr_hit & ~set_hit)) == '0));

  // R4
  a_r4_double_toggles: assert property (@(posedge clk) disable iff (rst)
    (|(set_hit & clr_hit)) |=>
      (((ctrl_o ^ $past(ctrl_o)) & $past(set_hit & clr_hit)) == $past(set_hit & clr_hit)));

  // R5
  a_r5_quiet_holds: assert property (@(posedge clk) disable iff (rst)
    ((set_hit | clr_hit) == '0) |=> $stable(ctrl_o));

  // R8
  a_r8_fast_holds: assert property (@(posedge clk) disable iff (rst)
    (fast_req_o && !fast_ack_i) |=> fast_req_o);
  a_r8_std_holds: assert property (@(posedge clk) disable iff (rst)
    (std_req_o && !std_ack_i) |=> std_req_o);
  a_r8_fast_drops: assert property (@(posedge clk) disable iff (rst)
    (fast_req_o && fast_ack_i) |=> !fast_req_o);
  a_r8_std_drops: assert property (@(posedge clk) disable iff (rst)
    (std_req_o && std_ack_i) |=> !std_req_o);

  // R10 / R11: a line only falls after its own acknowledge
  a_r11_fast_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(fast_req_o) |-> $past(fast_ack_i));
  a_r11_std_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(std_req_o) |-> $past(std_ack_i));
endmodule

bind pulse_ctrl_reg pulse_ctrl_reg_chk #(.NUM_CTRL(NUM_CTRL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .set_hit    (set_hit),
  .clr_hit    (clr_hit),
  .ctrl_o     (ctrl_o),
  .fast_req_o (fast_req_o),
  .std_req_o  (std_req_o),
  .fast_ack_i (fast_ack_i),
  .std_ack_i  (std_ack_i)
);

// File: tb/tb_pulse_ctrl_reg.sv
`timescale 1ns/1ps
module tb_pulse_ctrl_reg;
  localparam int NC  = 16;
  localparam int GAP = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cmd = '0;
  logic [31:0] status_o;
  logic [15:0] ctrl_o;
  logic        fe = 1'b0, se = 1'b0, fa = 1'b0, sa = 1'b0;
  logic        fast_req_o, std_req_o;

  pulse_ctrl_reg dut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .status_o(status_o), .ctrl_o(ctrl_o),
    .fast_evt_i(fe), .std_evt_i(se), .fast_ack_i(fa), .std_ack_i(sa),
    .fast_req_o(fast_req_o), .std_req_o(std_req_o)
  );

  always #4 clk = ~clk; // 125 MHz

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    done = 0;
  string tag_c = "R1";
  string tag_i = "R1";

  // behavioural reference model
  logic [31:0] m_prev = '0;
  logic [15:0] m_ctrl = '0;
  int m_hi[2], m_pend[2], m_gap[2];

  task automatic line_step(input int l, input logic ev, input logic ak);
    if (m_hi[l] != 0) begin
      if (ev) m_pend[l] = 1;
      if (ak) begin m_hi[l] = 0; m_gap[l] = GAP; end
    end else if (m_gap[l] > 1) begin
      m_gap[l]--;
      if (ev) m_pend[l] = 1;
    end else begin
      m_gap[l] = 0;
      if (ev || m_pend[l] != 0) begin m_hi[l] = 1; m_pend[l] = 0; end
    end
  endtask

  task automatic check1(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        m_prev = '0; m_ctrl = '0;
        for (int l = 0; l < 2; l++) begin m_hi[l] = 0; m_pend[l] = 0; m_gap[l] = 0; end
      end else begin
        for (int i = 0; i < NC; i++) begin
          bit s, c;
          s = cmd[2*i] && !m_prev[2*i];
          c = cmd[2*i+1] && !m_prev[2*i+1];
          if (s && c) m_ctrl[i] = !m_ctrl[i];
          else if (s) m_ctrl[i] = 1'b1;
          else if (c) m_ctrl[i] = 1'b0;
        end
        m_prev = cmd;
        line_step(0, fe, fa);
        line_step(1, se, sa);
      end
      check1(tag_c, "ctrl_o", {16'h0, ctrl_o}, {16'h0, m_ctrl});
      check1("R6", "status_o", status_o, {16'h0, m_ctrl});
      check1(tag_i, "fast_req_o", {31'h0, fast_req_o}, {31'h0, m_hi[0] != 0});
      check1(tag_i, "std_req_o", {31'h0, std_req_o}, {31'h0, m_hi[1] != 0});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired actual %0d expected below 50000", cycles);
      finish_run();
    end
  end

  task automatic step(input logic [31:0] c, input logic f_e, input logic s_e,
                      input logic f_a, input logic s_a);
    @(negedge clk); #1;
    cmd = c; fe = f_e; se = s_e; fa = f_a; sa = s_a;
  endtask

  task automatic wr(input logic [31:0] c);
    step(c, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) wr(cmd);
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    // R1: reset with all inputs quiet, then with commands present
    repeat (4) @(negedge clk);
    #1 cmd = 32'hFFFF_FFFF; fe = 1; se = 1;
    repeat (2) @(negedge clk);
    #1 cmd = '0; fe = 0; se = 0; rst = 0;
    idle(2);

    tag_c = "R2";
    wr(32'h0000_0001); wr(32'h0);
    wr(32'h5555_5555); wr(32'h0);
    tag_c = "R3";
    wr(32'h0000_0002); wr(32'h0);
    wr(32'hAAAA_AAAA); wr(32'h0);
    tag_c = "R5";
    wr(32'h0000_0001); idle(3);      // set, bit held high
    wr(32'h0000_0003); idle(2);      // clear edge while set still held
    wr(32'h0000_0002); wr(32'h0);    // falling bits do nothing
    wr(32'h0000_0001); wr(32'h0000_0001);
    tag_c = "R4";
    wr(32'h0); wr(32'h0000_0003); wr(32'h0); wr(32'h0000_0003); wr(32'h0);
    wr(32'hF0F0_5A3C); wr(32'h0); wr(32'hFFFF_FFFF); wr(32'h0);
    wr(32'h3333_3333); wr(32'h1111_1111);

    tag_c = "R2";
    for (int k = 0; k < 400; k++) begin lfsr = nxt(lfsr); wr(lfsr); end
    wr(32'h0);

    // interrupts
    tag_i = "R7";
    step(cmd, 1, 0, 0, 0); step(cmd, 0, 0, 0, 0); idle(3);
    tag_i = "R8";
    step(cmd, 0, 0, 1, 0); step(cmd, 0, 0, 0, 0); idle(2);
    tag_i = "R10";
    step(cmd, 0, 0, 1, 1); step(cmd, 0, 0, 0, 0); idle(2);
    tag_i = "R9";
    step(cmd, 1, 0, 0, 0); step(cmd, 1, 0, 0, 0); idle(2); // request while high
    step(cmd, 0, 0, 1, 0); step(cmd, 0, 0, 0, 0); idle(3);
    step(cmd, 0, 0, 1, 0);                                  // drop
    step(cmd, 1, 0, 0, 0); step(cmd, 0, 0, 0, 0); idle(2);  // request inside gap
    step(cmd, 1, 0, 1, 0); step(cmd, 0, 0, 0, 0); idle(2);  // request with ack
    step(cmd, 0, 0, 1, 0); idle(3);
    tag_i = "R11";
    step(cmd, 0, 1, 0, 0); idle(2);
    step(cmd, 1, 0, 0, 1); idle(2);
    step(cmd, 0, 0, 1, 0); idle(2);

    tag_c = "R4"; tag_i = "R9";
    for (int k = 0; k < 600; k++) begin
      lfsr = nxt(lfsr);
      step(lfsr & nxt(lfsr), lfsr[3] & lfsr[7], lfsr[11] & lfsr[5],
           lfsr[13], lfsr[17] | lfsr[19]);
    end
    idle(3);

    tag_c = "R1"; tag_i = "R1";
    @(negedge clk); #1 rst = 1;
    idle(3);
    @(negedge clk); #1 rst = 0;
    idle(2);
    finish_run();
  end
endmodule